// File: doc/BRIEF.md
# Super I/O Configuration Register Controller

This block sits on a legacy 8-bit I/O bus and owns the setup of a group of standard PC peripherals. It answers at two addresses: an index port (0x3F0) and a data port (0x3F1). Behind them is a file of sixteen 8-bit configuration registers. Software can reach these registers only after it writes a two-byte unlock key, and it leaves configuration mode with an exit byte.

From the first three registers the block decodes, with no added latency, the resource settings for the peripherals. These are:
- the enable, base address and IRQ of two serial ports;
- the base and IRQ of the parallel port;
- the floppy enable;
- the IDE channel enable.

The serial ports take their base addresses either from two fixed legacy locations or from a selectable pair of alternate addresses.

A data write that changes the bits behind a resource raises a one-clock reconfigure strobe for that resource. The peripheral controllers use these strobes to re-seat their decoders.

Top module: `sio_cfg_ctrl`

## Requirements
- R1: After reset the block is locked. Two writes of 0x55 to the index port enter configuration mode (`cfg_mode`=1). Index-port writes of any other value while locked neither advance nor clear the count of 0x55 writes. Data-port writes while locked do not touch the count.
- R2: In configuration mode, an index-port write of 0xAA leaves configuration mode, and a fresh pair of 0x55 writes is then needed. Any other index-port write loads the 8-bit register index.
- R3: A data-port write updates the indexed register only in configuration mode and only when the index is 15 or less. All other data writes leave every register unchanged.
- R4: `bus_rdata` shows the indexed register while `bus_rd` is high on the data port in configuration mode with an index of 15 or less. In every other case it is 0x00, including index-port reads and reads while locked.
- R5: Reset values are: register 0 = 0x3F, register 1 = 0x9F, register 2 = 0xDC, and all other registers 0x00.
- R6: Register 1 bits [6:5] select the alternate pair (ALT_A/ALT_B): 00 gives 0x338/0x238, 01 gives 0x3E8/0x2E8, 10 gives 0x3E8/0x2E0, 11 gives 0x220/0x228.
- R7: Serial port 0 uses register 2 bits [2:0] and serial port 1 uses bits [6:4]. In each field the top bit is the enable. The low two bits select the base and IRQ: 0 gives 0x3F8 with IRQ 4, 1 gives 0x2F8 with IRQ 3, 2 gives ALT_A with IRQ 4, 3 gives ALT_B with IRQ 3. A disabled port reports base 0 and IRQ 0.
- R8: Register 1 bits [1:0] select the parallel port: 0 disabled (base 0, IRQ 0), 1 gives 0x3BC, 2 gives 0x378, 3 gives 0x278. All enabled cases use IRQ 7.
- R9: `fdc_en` equals register 0 bit 4, with base 0x3F0. `ide_en` equals register 0 bit 0 when parameter HAS_IDE is 1, with bases 0x1F0/0x3F6. It is always 0 when HAS_IDE is 0.
- R10: One clock after a register write that changes them, strobes fire as follows:
  - `uart0_reconf` pulses for a change in register 2 bits [2:0] or register 1 bits [6:5];
  - `uart1_reconf` pulses for a change in register 2 bits [6:4] or register 1 bits [6:5];
  - `lpt_reconf` pulses for a change in register 1 bits [1:0];
  - `fdc_reconf` pulses for a change in register 0 bit 4;
  - `ide_reconf` pulses for a change in register 0 bit 0, and only when HAS_IDE is 1.

  A write that changes none of the bits behind a strobe leaves that strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | I/O address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| cfg_mode | output | 1 | High while configuration registers are unlocked |
| uart0_en | output | 1 | Serial port 0 enable |
| uart0_base | output | 16 | Serial port 0 base address |
| uart0_irq | output | 4 | Serial port 0 IRQ |
| uart1_en | output | 1 | Serial port 1 enable |
| uart1_base | output | 16 | Serial port 1 base address |
| uart1_irq | output | 4 | Serial port 1 IRQ |
| lpt_en | output | 1 | Parallel port enable |
| lpt_base | output | 16 | Parallel port base address |
| lpt_irq | output | 4 | Parallel port IRQ |
| fdc_en | output | 1 | Floppy controller enable |
| fdc_base | output | 16 | Floppy controller base address |
| ide_en | output | 1 | IDE channel enable |
| ide_cmd_base | output | 16 | IDE command block base |
| ide_ctl_base | output | 16 | IDE control block base |
| uart0_reconf | output | 1 | Serial port 0 reconfigure strobe |
| uart1_reconf | output | 1 | Serial port 1 reconfigure strobe |
| lpt_reconf | output | 1 | Parallel port reconfigure strobe |
| fdc_reconf | output | 1 | Floppy reconfigure strobe |
| ide_reconf | output | 1 | IDE reconfigure strobe |

## Verification
Timing of each result:
- A write changes register contents, `cfg_mode` and the decoded resource outputs at the clock edge that samples it.
- The reconfigure strobes are registered at that same edge, so they are high for exactly the cycle that follows it.
- Read data is combinational and valid while `bus_rd` is held.

The bench drives each access at a falling edge. It samples strobes and decoded outputs 1 ns after the capturing rising edge. It confirms that each strobe is low again one full cycle later. It samples read data a few nanoseconds after raising `bus_rd`, before any rising edge matters.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam int          REG_W     = 8;
    localparam int          ADDR_BITS = 16;
    localparam logic [7:0]  KEY_ENTER = 8'h55;
    localparam logic [7:0]  KEY_EXIT  = 8'hAA;
    localparam logic [15:0] FDC_BASE  = 16'h03F0;
    localparam logic [15:0] IDE_CMD   = 16'h01F0;
    localparam logic [15:0] IDE_CTL   = 16'h03F6;

    typedef enum logic [1:0] {
        LK_IDLE = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_state_t;

    typedef struct packed {
        logic        en;
        logic [15:0] base;
        logic [3:0]  irq;
    } res_t;

    typedef struct packed {
        logic [15:0] alt_a;
        logic [15:0] alt_b;
    } alt_pair_t;

    typedef struct packed {
        logic uart0;
        logic uart1;
        logic lpt;
        logic fdc;
        logic ide;
    } reconf_t;

    function automatic logic [7:0] reset_value(input int idx);
        case (idx)
            0:       return 8'h3F;
            1:       return 8'h9F;
            2:       return 8'hDC;
            default: return 8'h00;
        endcase
    endfunction

    function automatic alt_pair_t alt_pair(input logic [1:0] sel);
        alt_pair_t p;
        case (sel)
            2'd0:    begin p.alt_a = 16'h0338; p.alt_b = 16'h0238; end
            2'd1:    begin p.alt_a = 16'h03E8; p.alt_b = 16'h02E8; end
            2'd2:    begin p.alt_a = 16'h03E8; p.alt_b = 16'h02E0; end
            default: begin p.alt_a = 16'h0220; p.alt_b = 16'h0228; end
        endcase
        return p;
    endfunction

    function automatic res_t uart_res(input logic [2:0] fld, input alt_pair_t p);
        res_t r;
        r = '0;
        if (fld[2]) begin
            r.en = 1'b1;
            case (fld[1:0])
                2'd0:    begin r.base = 16'h03F8; r.irq = 4'd4; end
                2'd1:    begin r.base = 16'h02F8; r.irq = 4'd3; end
                2'd2:    begin r.base = p.alt_a;  r.irq = 4'd4; end
                default: begin r.base = p.alt_b;  r.irq = 4'd3; end
            endcase
        end
        return r;
    endfunction

    function automatic res_t lpt_res(input logic [1:0] mode);
        res_t r;
        r = '0;
        if (mode != 2'd0) begin
            r.en  = 1'b1;
            r.irq = 4'd7;
            case (mode)
                2'd1:    r.base = 16'h03BC;
                2'd2:    r.base = 16'h0378;
                default: r.base = 16'h0278;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/sio_unlock.sv
module sio_unlock
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_mode,
    output logic [7:0] index
);

    lock_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= LK_IDLE;
            index <= 8'h00;
        end else if (idx_wr) begin
            case (st_q)
                LK_OPEN: begin
                    if (wdata == KEY_EXIT) st_q  <= LK_IDLE;
                    else                   index <= wdata;
                end
                LK_HALF: if (wdata == KEY_ENTER) st_q <= LK_OPEN;
                default: if (wdata == KEY_ENTER) st_q <= LK_HALF;
            endcase
        end
    end

    assign cfg_mode = (st_q == LK_OPEN);

    // R1
    unlock_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (idx_wr && wdata == KEY_ENTER && st_q == LK_HALF) |=> cfg_mode);

    // R1
    unlock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_mode && !(idx_wr && wdata == KEY_ENTER)) |=> $stable(st_q));

    // R2
    unlock_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && idx_wr && wdata == KEY_EXIT) |=> !cfg_mode);

endmodule

// File: rtl/sio_regfile.sv
module sio_regfile
    import sio_cfg_pkg::*;
#(
    parameter int NREG    = 16,
    parameter bit HAS_IDE = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  data_wr,
    input  logic [7:0]            index,
    input  logic [7:0]            wdata,
    output logic [NREG-1:0][7:0]  regs_q,
    output reconf_t               reconf
);

    localparam logic [7:0] LAST_IDX = 8'(NREG - 1);

    logic in_range;
    logic [7:0] old_val;
    logic [7:0] diff;

    assign in_range = (index <= LAST_IDX);
    assign old_val  = in_range ? regs_q[index[$clog2(NREG)-1:0]] : 8'h00;
    assign diff     = old_val ^ wdata;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= reset_value(g);
            else if (data_wr && in_range && index == 8'(g))
                regs_q[g] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reconf <= '0;
        end else begin
            reconf <= '0;
            if (data_wr && in_range) begin
                case (index)
                    8'd0: begin
                        reconf.fdc <= diff[4];
                        reconf.ide <= HAS_IDE && diff[0];
                    end
                    8'd1: begin
                        reconf.lpt   <= |diff[1:0];
                        reconf.uart0 <= |diff[6:5];
                        reconf.uart1 <= |diff[6:5];
                    end
                    8'd2: begin
                        reconf.uart0 <= |diff[2:0];
                        reconf.uart1 <= |diff[6:4];
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3
    regs_locked_chk: assert property (@(posedge clk) disable iff (rst)
        (!data_wr || !in_range) |=> $stable(regs_q));

    // R10
    strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (reconf != '0) |-> $past(data_wr && in_range));

    // R10
    lpt_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (data_wr && index == 8'd1 && wdata[1:0] != regs_q[1][1:0]) |=> reconf.lpt);

endmodule

// File: rtl/sio_decode.sv
module sio_decode
    import sio_cfg_pkg::*;
#(
    parameter bit HAS_IDE = 1'b1
) (
    input  logic [7:0] r0,
    input  logic [7:0] r1,
    input  logic [7:0] r2,
    output res_t       uart0,
    output res_t       uart1,
    output res_t       lpt,
    output logic       fdc_en,
    output logic       ide_en
);

    alt_pair_t pair;
    res_t      uart_v [2];

    assign pair = alt_pair(r1[6:5]);

    for (genvar p = 0; p < 2; p++) begin : g_uart
        assign uart_v[p] = uart_res(r2[4*p +: 3], pair);
    end

    assign uart0  = uart_v[0];
    assign uart1  = uart_v[1];
    assign lpt    = lpt_res(r1[1:0]);
    assign fdc_en = r0[4];

    if (HAS_IDE) begin : g_ide
        assign ide_en = r0[0];
    end else begin : g_no_ide
        assign ide_en = 1'b0;
    end

endmodule

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
    import sio_cfg_pkg::*;
#(
    parameter int              ADDR_W    = ADDR_BITS,
    parameter logic [ADDR_W-1:0] INDEX_PORT = ADDR_W'(16'h03F0),
    parameter int              NREG      = 16,
    parameter bit              HAS_IDE   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              cfg_mode,
    output logic              uart0_en,
    output logic [15:0]       uart0_base,
    output logic [3:0]        uart0_irq,
    output logic              uart1_en,
    output logic [15:0]       uart1_base,
    output logic [3:0]        uart1_irq,
    output logic              lpt_en,
    output logic [15:0]       lpt_base,
    output logic [3:0]        lpt_irq,
    output logic              fdc_en,
    output logic [15:0]       fdc_base,
    output logic              ide_en,
    output logic [15:0]       ide_cmd_base,
    output logic [15:0]       ide_ctl_base,
    output logic              uart0_reconf,
    output logic              uart1_reconf,
    output logic              lpt_reconf,
    output logic              fdc_reconf,
    output logic              ide_reconf
);

    localparam logic [ADDR_W-1:0] DATA_PORT = INDEX_PORT + ADDR_W'(1);
    localparam logic [7:0]        LAST_IDX  = 8'(NREG - 1);

    logic hit_idx, hit_data;
    logic [7:0] index;
    logic [NREG-1:0][7:0] regs_q;
    reconf_t reconf;
    res_t u0, u1, lp;

    assign hit_idx  = (bus_addr == INDEX_PORT);
    assign hit_data = (bus_addr == DATA_PORT);

    sio_unlock u_unlock (
        .clk      (clk),
        .rst      (rst),
        .idx_wr   (bus_wr && hit_idx),
        .wdata    (bus_wdata),
        .cfg_mode (cfg_mode),
        .index    (index)
    );

    sio_regfile #(.NREG(NREG), .HAS_IDE(HAS_IDE)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .data_wr (bus_wr && hit_data && cfg_mode),
        .index   (index),
        .wdata   (bus_wdata),
        .regs_q  (regs_q),
        .reconf  (reconf)
    );

    sio_decode #(.HAS_IDE(HAS_IDE)) u_dec (
        .r0     (regs_q[0]),
        .r1     (regs_q[1]),
        .r2     (regs_q[2]),
        .uart0  (u0),
        .uart1  (u1),
        .lpt    (lp),
        .fdc_en (fdc_en),
        .ide_en (ide_en)
    );

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd && hit_data && cfg_mode && index <= LAST_IDX)
            bus_rdata = regs_q[index[$clog2(NREG)-1:0]];
    end

    assign uart0_en     = u0.en;
    assign uart0_base   = u0.base;
    assign uart0_irq    = u0.irq;
    assign uart1_en     = u1.en;
    assign uart1_base   = u1.base;
    assign uart1_irq    = u1.irq;
    assign lpt_en       = lp.en;
    assign lpt_base     = lp.base;
    assign lpt_irq      = lp.irq;
    assign fdc_base     = FDC_BASE;
    assign ide_cmd_base = IDE_CMD;
    assign ide_ctl_base = IDE_CTL;
    assign uart0_reconf = reconf.uart0;
    assign uart1_reconf = reconf.uart1;
    assign lpt_reconf   = reconf.lpt;
    assign fdc_reconf   = reconf.fdc;
    assign ide_reconf   = reconf.ide;

    // R4
    locked_read_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |-> bus_rdata == 8'h00);

    // R8
    lpt_irq_chk: assert property (@(posedge clk) disable iff (rst)
        lpt_en |-> lpt_irq == 4'd7);

endmodule

// File: tb/sio_cfg_ctrl_test.sv
module sio_cfg_ctrl_test;

    localparam logic [15:0] IDXP = 16'h03F0;
    localparam logic [15:0] DATP = 16'h03F1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        cfg_mode;
    logic        uart0_en, uart1_en, lpt_en, fdc_en, ide_en;
    logic [15:0] uart0_base, uart1_base, lpt_base, fdc_base, ide_cmd_base, ide_ctl_base;
    logic [3:0]  uart0_irq, uart1_irq, lpt_irq;
    logic        uart0_reconf, uart1_reconf, lpt_reconf, fdc_reconf, ide_reconf;

    int nchk = 0, nfail = 0;
    logic [7:0] m_regs [16];
    int m_cnt = 0;
    logic [7:0] m_idx = 0;
    logic [4:0] exp_stb;

    always #5 clk = ~clk;

    sio_cfg_ctrl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_mode(cfg_mode),
        .uart0_en(uart0_en), .uart0_base(uart0_base), .uart0_irq(uart0_irq),
        .uart1_en(uart1_en), .uart1_base(uart1_base), .uart1_irq(uart1_irq),
        .lpt_en(lpt_en), .lpt_base(lpt_base), .lpt_irq(lpt_irq),
        .fdc_en(fdc_en), .fdc_base(fdc_base), .ide_en(ide_en),
        .ide_cmd_base(ide_cmd_base), .ide_ctl_base(ide_ctl_base),
        .uart0_reconf(uart0_reconf), .uart1_reconf(uart1_reconf),
        .lpt_reconf(lpt_reconf), .fdc_reconf(fdc_reconf), .ide_reconf(ide_reconf)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] e_alt(input bit second);
        case (m_regs[1][6:5])
            2'd0: return second ? 32'h238 : 32'h338;
            2'd1: return second ? 32'h2E8 : 32'h3E8;
            2'd2: return second ? 32'h2E0 : 32'h3E8;
            default: return second ? 32'h228 : 32'h220;
        endcase
    endfunction

    // returns {en, base[15:0], irq[3:0]}
    function automatic logic [20:0] e_uart(input int p);
        logic [2:0] f;
        f = (p == 0) ? m_regs[2][2:0] : m_regs[2][6:4];
        if (!f[2]) return 21'h0;
        case (f[1:0])
            2'd0: return {1'b1, 16'h03F8, 4'd4};
            2'd1: return {1'b1, 16'h02F8, 4'd3};
            2'd2: return {1'b1, e_alt(0)[15:0], 4'd4};
            default: return {1'b1, e_alt(1)[15:0], 4'd3};
        endcase
    endfunction

    function automatic logic [20:0] e_lpt();
        case (m_regs[1][1:0])
            2'd0: return 21'h0;
            2'd1: return {1'b1, 16'h03BC, 4'd7};
            2'd2: return {1'b1, 16'h0378, 4'd7};
            default: return {1'b1, 16'h0278, 4'd7};
        endcase
    endfunction

    task automatic check_outputs(input string tag);
        check("R7", {tag, " uart0"}, {11'h0, uart0_en, uart0_base, uart0_irq}, {11'h0, e_uart(0)});
        check("R7", {tag, " uart1"}, {11'h0, uart1_en, uart1_base, uart1_irq}, {11'h0, e_uart(1)});
        check("R8", {tag, " lpt"}, {11'h0, lpt_en, lpt_base, lpt_irq}, {11'h0, e_lpt()});
        check("R9", {tag, " fdc/ide"}, {14'h0, fdc_en, ide_en, fdc_base},
              {14'h0, m_regs[0][4], m_regs[0][0], 16'h03F0});
    endtask

    // model of one bus write; sets expected strobes {u0,u1,lpt,fdc,ide}
    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        logic [7:0] x;
        exp_stb = '0;
        if (a == IDXP) begin
            if (m_cnt == 2) begin
                if (d == 8'hAA) m_cnt = 0;
                else m_idx = d;
            end else if (d == 8'h55) m_cnt++;
        end else if (a == DATP && m_cnt == 2 && m_idx <= 8'd15) begin
            x = m_regs[m_idx[3:0]] ^ d;
            m_regs[m_idx[3:0]] = d;
            case (m_idx)
                8'd0: exp_stb = {3'b000, x[4], x[0]};
                8'd1: exp_stb = {|x[6:5], |x[6:5], |x[1:0], 2'b00};
                8'd2: exp_stb = {|x[2:0], |x[6:4], 3'b000};
                default: exp_stb = '0;
            endcase
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        model_write(a, d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        check("R10", "strobes after write",
              {27'h0, uart0_reconf, uart1_reconf, lpt_reconf, fdc_reconf, ide_reconf},
              {27'h0, exp_stb});
        check("R1", "cfg_mode", {31'h0, cfg_mode}, {31'h0, m_cnt == 2});
        @(negedge clk);
        bus_wr = 1'b0;
        @(posedge clk); #1;
        check("R10", "strobes one cycle later",
              {27'h0, uart0_reconf, uart1_reconf, lpt_reconf, fdc_reconf, ide_reconf}, 32'h0);
    endtask

    task automatic rd(input logic [15:0] a, input string req);
        logic [7:0] e;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2;
        e = (a == DATP && m_cnt == 2 && m_idx <= 8'd15) ? m_regs[m_idx[3:0]] : 8'h00;
        check(req, "read data", {24'h0, bus_rdata}, {24'h0, e});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        #1_500_000;
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5107;
        void'($urandom(seed));
        for (int i = 0; i < 16; i++) m_regs[i] = 8'h00;
        m_regs[0] = 8'h3F; m_regs[1] = 8'h9F; m_regs[2] = 8'hDC;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R5 reset state through decoded outputs
        check("R5", "cfg_mode after reset", {31'h0, cfg_mode}, 32'h0);
        check_outputs("R5 reset");
        // R4 locked reads
        rd(DATP, "R4");
        rd(IDXP, "R4");
        // R3 data write while locked ignored
        wr(DATP, 8'h00);
        check_outputs("R3 locked write");
        // R1 unlock with junk in between
        wr(IDXP, 8'h55);
        wr(IDXP, 8'h12);
        wr(DATP, 8'h77);
        wr(IDXP, 8'h55);
        check("R1", "unlocked", {31'h0, cfg_mode}, 32'h1);
        // R5 read back all registers
        for (int i = 0; i < 16; i++) begin
            wr(IDXP, 8'(i));
            rd(DATP, "R5");
        end
        rd(IDXP, "R4");
        // R3 out-of-range index
        wr(IDXP, 8'h10);
        wr(DATP, 8'hFF);
        rd(DATP, "R4");
        for (int i = 0; i < 3; i++) begin
            wr(IDXP, 8'(i));
            rd(DATP, "R3");
        end
        // R6 all alternate pairs, both ports on alt addresses
        wr(IDXP, 8'h02); wr(DATP, 8'h76);
        wr(IDXP, 8'h01);
        for (int s = 0; s < 4; s++) begin
            wr(DATP, {1'b1, 2'(s), 5'h02});
            check_outputs("R6 pair");
        end
        // R8 parallel modes
        for (int s = 0; s < 4; s++) begin
            wr(DATP, {1'b1, 2'd0, 3'h0, 2'(s)});
            check_outputs("R8 mode");
        end
        // R9 floppy / ide toggles
        wr(IDXP, 8'h00);
        wr(DATP, 8'h00); check_outputs("R9 off");
        wr(DATP, 8'h11); check_outputs("R9 on");
        wr(DATP, 8'h11); check_outputs("R10 no change");
        // R2 exit then locked
        wr(IDXP, 8'hAA);
        check("R2", "locked after exit", {31'h0, cfg_mode}, 32'h0);
        wr(IDXP, 8'h55);
        check("R2", "single key stays locked", {31'h0, cfg_mode}, 32'h0);
        wr(IDXP, 8'h55);
        // random phase
        for (int n = 0; n < 400; n++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 4) begin
                wr(IDXP, 8'($urandom_range(0, 3)));
                wr(DATP, 8'($urandom));
                check_outputs("R7 random");
            end else if (k < 6) begin
                rd(DATP, "R4");
            end else if (k == 6) begin
                wr(IDXP, 8'hAA);
                rd(DATP, "R4");
            end else if (k == 7) begin
                wr(IDXP, 8'h55);
            end else if (k == 8) begin
                wr(IDXP, 8'($urandom));
            end else begin
                wr(DATP, 8'($urandom));
                check_outputs("R3 random");
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule